// File: doc/BRIEF.md
# Edge-Masked Pin Interrupt Controller

This block watches a bank of general-purpose pin levels and a thermal-fault flag, and latches a single pending interrupt when a watched input changes. Every pin has one mask bit for its low-to-high change and a separate mask bit for its high-to-low change. The controller keeps two complete sets of these masks, one for normal operation and one for suspend operation. A mode input selects which set applies. A rising thermal-fault flag always raises the interrupt and cannot be masked.

The pending interrupt drives an active-low, open-drain alert line. The block models that line as an output enable: when the enable is high, the pad pulls the line low. Two strobes clear the pending state. One is the alert-response acknowledge from the host. The other is the software power-on reset, which also returns all four mask registers to their reset values. Once the interrupt has latched, setting a mask bit does not clear it.

The pending logic is a two-state machine with the states QUIET and ALERT. It takes the transition RAISE from QUIET to ALERT on any qualified event. It takes HOLD from ALERT back to ALERT when no clear arrives, or when a clear arrives in the same cycle as a new event. It takes CLEAR from ALERT to QUIET when a clear arrives with no event. In QUIET with no event, it stays in QUIET through IDLE.

Top module: `pinwatch_irq`

## Requirements
- R1: After reset, alert_oe is 0 and all four mask registers hold all ones, so no pin change raises the alert.
- R2: An unmasked change on a pin raises alert_oe three rising clock edges after the pin changes. alert_oe is still 0 after two edges.
- R3: Rising and falling edges are masked independently. A mask bit value of 1 means masked. Clearing only a pin's rising mask bit lets its rise through and still blocks its fall.
- R4: suspend_mode = 0 applies the normal mask pair. suspend_mode = 1 applies the suspend mask pair.
- R5: A rising edge of thermal_fault raises alert_oe whatever the masks hold. A falling edge of thermal_fault raises nothing.
- R6: While the interrupt is pending, alert_oe stays 1 until a clear. Writing mask bits to 1 does not clear it.
- R7: A one-cycle alert_ack clears the pending interrupt, and alert_oe is 0 in the following cycle.
- R8: A one-cycle soft_por clears the pending interrupt and restores all four mask registers to all ones.
- R9: If a qualified event is detected in the same cycle as a clear, the interrupt stays pending.
- R10: A mask write loads mask_data into the register chosen by mask_sel. The encoding is 0 for normal-rise, 1 for normal-fall, 2 for suspend-rise and 3 for suspend-fall.
- R11: A pin that holds a steady level, or a masked change, leaves alert_oe unchanged at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Asynchronous pin levels |
| thermal_fault | input | 1 | Asynchronous thermal-fault flag |
| suspend_mode | input | 1 | 1 selects the suspend mask pair |
| mask_wr | input | 1 | Mask register write strobe |
| mask_sel | input | 2 | Mask register select |
| mask_data | input | NPIN | Mask write data, 1 = masked |
| soft_por | input | 1 | Software reset strobe |
| alert_ack | input | 1 | Alert-response acknowledge strobe |
| alert_oe | output | 1 | Pull-down enable for the open-drain alert line |

## Verification
The only visible state is the pending bit, so a state machine stuck in ALERT or QUIET shows up on alert_oe at the first check after a clear or an event. That is three cycles after a pin change, or one cycle after a strobe. A corrupted mask register shows up only when a pin edge is tested against the affected bit under the matching mode. For that reason, the vector table covers each mask register, each edge direction and both modes. Detection that is late or early by one synchroniser stage is caught by sampling alert_oe both two and three edges after a pin change.

// File: rtl/pwi_pkg.sv
package pwi_pkg;
    typedef enum logic [1:0] {
        MSEL_NRISE = 2'd0,
        MSEL_NFALL = 2'd1,
        MSEL_SRISE = 2'd2,
        MSEL_SFALL = 2'd3
    } msel_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } pend_e;

    localparam int NUM_MASK_REGS = 4;
endpackage

// File: rtl/pwi_sync.sv
module pwi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwi_edge.sv
module pwi_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/pwi_maskbank.sv
module pwi_maskbank #(
    parameter int W    = 8,
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_por,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_sel,
    input  logic [W-1:0]             wr_data,
    output logic [NREG-1:0][W-1:0]   regs
);
    localparam int SELW = $clog2(NREG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '1;
        end else if (soft_por) begin
            regs <= '1;
        end else if (wr_en) begin
            for (int g = 0; g < NREG; g++) begin
                if (wr_sel == SELW'(g)) regs[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pinwatch_irq.sv
module pinwatch_irq
    import pwi_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic            thermal_fault,
    input  logic            suspend_mode,
    input  logic            mask_wr,
    input  logic [1:0]      mask_sel,
    input  logic [NPIN-1:0] mask_data,
    input  logic            soft_por,
    input  logic            alert_ack,
    output logic            alert_oe
);
    localparam int SW = NPIN + 1;   // pins plus thermal flag

    logic [SW-1:0] sync_q;
    logic [SW-1:0] rise_v;
    logic [SW-1:0] fall_v;
    logic [NUM_MASK_REGS-1:0][NPIN-1:0] mask_regs;
    logic [NPIN-1:0] rmask;
    logic [NPIN-1:0] fmask;
    logic [SW-1:0]   rise_mx;
    logic [SW-1:0]   fall_mx;
    logic            set_evt;
    logic            therm_rise;
    logic            clr_req;
    pend_e           state, nxt;

    pwi_sync #(.W(SW), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({thermal_fault, pin_in}),
        .q    (sync_q)
    );

    pwi_edge #(.W(SW)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sync_q),
        .rise (rise_v),
        .fall (fall_v)
    );

    pwi_maskbank #(.W(NPIN), .NREG(NUM_MASK_REGS)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_por(soft_por),
        .wr_en   (mask_wr),
        .wr_sel  (mask_sel),
        .wr_data (mask_data),
        .regs    (mask_regs)
    );

    // mode picks the active mask pair
    assign rmask = suspend_mode ? mask_regs[MSEL_SRISE] : mask_regs[MSEL_NRISE];
    assign fmask = suspend_mode ? mask_regs[MSEL_SFALL] : mask_regs[MSEL_NFALL];

    // thermal rise never masked, thermal fall always masked
    assign rise_mx = {1'b0, rmask};
    assign fall_mx = {1'b1, fmask};

    assign therm_rise = rise_v[NPIN];
    assign set_evt    = |(rise_v & ~rise_mx) | |(fall_v & ~fall_mx);
    assign clr_req    = soft_por | alert_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_QUIET: if (set_evt)              nxt = ST_ALERT;  // RAISE
            ST_ALERT: if (clr_req && !set_evt)  nxt = ST_QUIET;  // CLEAR
            default:                            nxt = ST_QUIET;
        endcase
    end

    always_comb begin
        alert_oe = (state == ST_ALERT);
    end
endmodule

// File: rtl/pwi_chk.sv
module pwi_chk #(
    parameter int NPIN = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alert_oe,
    input logic                  alert_ack,
    input logic                  soft_por,
    input logic                  set_evt,
    input logic                  therm_rise,
    input logic [3:0][NPIN-1:0]  mask_regs
);
    a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> alert_oe);

    a_r5_thermal_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        therm_rise |=> alert_oe);

    a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_oe && !alert_ack && !soft_por) |=> alert_oe);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_ack && !set_evt) |=> !alert_oe);

    a_r8_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_por && !set_evt) |=> !alert_oe);

    a_r8_por_masks: assert property (@(posedge clk) disable iff (!rst_n)
        soft_por |=> (mask_regs == '1));

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_oe && !set_evt) |=> !alert_oe);
endmodule

bind pinwatch_irq pwi_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alert_oe  (alert_oe),
    .alert_ack (alert_ack),
    .soft_por  (soft_por),
    .set_evt   (set_evt),
    .therm_rise(therm_rise),
    .mask_regs (mask_regs)
);

// File: tb/sim_pinwatch_irq.sv
module sim_pinwatch_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       thermal_fault = 1'b0;
    logic       suspend_mode = 1'b0;
    logic       mask_wr = 1'b0;
    logic [1:0] mask_sel = 2'd0;
    logic [7:0] mask_data = 8'h00;
    logic       soft_por = 1'b0;
    logic       alert_ack = 1'b0;
    logic       alert_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pinwatch_irq #(.NPIN(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .thermal_fault(thermal_fault),
        .suspend_mode(suspend_mode), .mask_wr(mask_wr), .mask_sel(mask_sel),
        .mask_data(mask_data), .soft_por(soft_por), .alert_ack(alert_ack),
        .alert_oe(alert_oe)
    );

    typedef struct packed {
        logic       mode;
        logic [7:0] nr, nf, sr, sf;
        logic [7:0] pb, pa;
        logic       exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'hFE, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h01, 1'b1},  // R2 unmasked rise
        '{1'b0, 8'hFE, 8'hFF, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0},  // R3 fall blocked
        '{1'b0, 8'hFF, 8'hFE, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b1},  // R3 fall open
        '{1'b1, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b0},  // R4 suspend masks apply
        '{1'b1, 8'hFF, 8'hFF, 8'h7F, 8'hFF, 8'h00, 8'h80, 1'b1},  // R4 suspend rise open
        '{1'b0, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h40, 1'b0},  // R11 masked pin
        '{1'b0, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h5A, 8'h5A, 1'b0},  // R11 steady
        '{1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hEF, 8'h10, 8'h00, 1'b1}   // R10 suspend fall
    };

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: alert_oe=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic wmask(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        mask_wr = 1'b1; mask_sel = s; mask_data = d;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); alert_ack = 1'b1;
        @(negedge clk); alert_ack = 1'b0;
    endtask

    task automatic pulse_por();
        @(negedge clk); soft_por = 1'b1;
        @(negedge clk); soft_por = 1'b0;
    endtask

    task automatic set_pins(logic [7:0] v);
        @(negedge clk); pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_clear(logic [7:0] v);
        @(negedge clk); pin_in = v;
        repeat (5) @(negedge clk);
        pulse_ack();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", alert_oe, 1'b0);
        set_pins(8'hFF);
        check("R1 default rise masks", alert_oe, 1'b0);
        set_pins(8'h00);
        check("R1 default fall masks", alert_oe, 1'b0);

        // table walk: R2 R3 R4 R10 R11
        for (int i = 0; i < NV; i++) begin
            wmask(2'd0, VECS[i].nr);
            wmask(2'd1, VECS[i].nf);
            wmask(2'd2, VECS[i].sr);
            wmask(2'd3, VECS[i].sf);
            suspend_mode = VECS[i].mode;
            settle_clear(VECS[i].pb);
            set_pins(VECS[i].pa);
            check($sformatf("R2/R3/R4/R10/R11 vector %0d", i), alert_oe, VECS[i].exp);
            pulse_ack();
        end

        // R2 latency
        suspend_mode = 1'b0;
        wmask(2'd0, 8'h00);
        settle_clear(8'h00);
        @(negedge clk); pin_in = 8'h01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not before third edge", alert_oe, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2 third edge", alert_oe, 1'b1);

        // R6 masking after the event
        wmask(2'd0, 8'hFF);
        wmask(2'd1, 8'hFF);
        repeat (3) @(negedge clk);
        check("R6 mask does not clear", alert_oe, 1'b1);

        // R7 ack clears
        pulse_ack();
        check("R7 ack clears", alert_oe, 1'b0);

        // R5 thermal with all masks set
        @(negedge clk); thermal_fault = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 thermal rise", alert_oe, 1'b1);
        @(negedge clk); thermal_fault = 1'b0;
        repeat (4) @(negedge clk);
        pulse_ack();
        repeat (4) @(negedge clk);
        check("R5 thermal fall ignored", alert_oe, 1'b0);

        // R9 event coincident with ack
        wmask(2'd0, 8'h00);
        settle_clear(8'h00);
        set_pins(8'h01);
        check("R9 pending before", alert_oe, 1'b1);
        @(negedge clk); pin_in = 8'h03;
        repeat (2) @(posedge clk);
        @(negedge clk); alert_ack = 1'b1;
        @(negedge clk); alert_ack = 1'b0;
        check("R9 event wins over ack", alert_oe, 1'b1);
        repeat (2) @(negedge clk);
        check("R9 still pending", alert_oe, 1'b1);

        // R8 soft reset clears and restores masks
        pulse_por();
        check("R8 por clears", alert_oe, 1'b0);
        set_pins(8'h00);
        check("R8 fall masked after por", alert_oe, 1'b0);
        set_pins(8'hFF);
        check("R8 rise masked after por", alert_oe, 1'b0);

        // R10 register select
        wmask(2'd3, 8'h00);
        suspend_mode = 1'b0;
        set_pins(8'h00);
        check("R10 suspend-fall unused in normal", alert_oe, 1'b0);
        suspend_mode = 1'b1;
        set_pins(8'hFF);
        check("R10 suspend-rise still masked", alert_oe, 1'b0);
        set_pins(8'h00);
        check("R10 suspend-fall open", alert_oe, 1'b1);
        pulse_ack();
        check("R7 ack clears again", alert_oe, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule